// File: doc/BRIEF.md
# Self-Repairing ECC Cache Lookup Stage

This block is a small direct-mapped cache that checks its own contents on every access. Each stored 32-bit word carries its own SEC-DED Hamming check bits. The valid bit and the tag of each line share a second, separate SEC-DED code. Every lookup decodes the tag code and the code of every word in the addressed line, not only the word that was requested.

The response to a failed check depends on whether the line is dirty:

- **Clean line.** A failure on a line that only holds a copy of lower memory is never trusted, even when the tag still matches. The block turns the hit into a miss, fetches the whole line again from the next level, rewrites it with fresh check bits, and then replays the held CPU request as an ordinary hit.
- **Dirty line.** A failure on a line that holds the only valid copy cannot be repaired by a refetch. The access completes, with single-bit errors corrected on the fly. The block raises a level interrupt and records which line failed and which code reported the failure.

The CPU port uses a valid/ready handshake and gives a registered response. The next-level port is a one-cycle request pulse that carries the line address, followed by one response beat per word, lowest word first. The state machine, the interrupt flag and the response flag are each held in three copies with a majority vote. A test-only port XORs a mask into a stored word or into the stored {valid, tag} field without touching the check bits, so that errors can be injected.

Top module: `ecc_refill_cache`

## Requirements
- R1: After reset every line is invalid: cpuReady is low for any address, and cpuRespValid, memReqValid and irq are low.
- R2: A read that hits with no check failure is accepted in the cycle cpuReady is high. cpuRespValid and cpuRdata appear on the next cycle, and no refill is issued. A write that hits stores the word and marks the line dirty, and a later read returns the written value.
- R3: On a miss, cpuReady stays low while a single memReqValid pulse carries the line address {tag, index} (cpuAddr[ADDR_W-1:OFF_W]). The block then takes WORDS response beats, lowest word first, and replays the held request as a hit.
- R4: Every lookup checks the {valid, tag} code and the code of every word of the indexed line, so an error in a word that was not requested still counts as a failure.
- R5: Any check failure on a clean line, whether single-bit or double-bit and in the tag or in the data, forces a refill even when the tag matches. The CPU receives the next-level data, irq stays low, and a later access to the repaired line hits without a refill.
- R6: A check failure on a dirty line issues no refill for a hit. irq is high from the cycle after the lookup, and a single-bit error in the returned word is corrected.
- R7: On a dirty-line failure, errIdx records the line index, errTag is 1 when the {valid, tag} code failed, and errData is 1 when any word code failed.
- R8: irq stays high through idle cycles until irqClear is pulsed, and is low on the cycle after the pulse.
- R9: A write miss first refills the line and then writes the word. The written word reads back, and the other words of the line hold the next-level data.
- R10: A miss on a valid clean line that holds a different tag replaces that line with the requested one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuValid | input | 1 | CPU request valid; must be held, with its fields unchanged, until cpuReady |
| cpuReady | output | 1 | Request accepted this cycle |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address: tag, index, word offset |
| cpuWdata | input | 32 | Write data |
| cpuRespValid | output | 1 | Response valid, one cycle after acceptance |
| cpuRdata | output | 32 | Read data (the written value for writes) |
| memReqValid | output | 1 | One-cycle refill request |
| memReqAddr | output | ADDR_W-OFF_W | Line address of the refill |
| memRespValid | input | 1 | Refill beat valid |
| memRespData | input | 32 | Refill beat data |
| irq | output | 1 | Dirty-line check failure, held high until cleared |
| irqClear | input | 1 | Clears irq |
| errIdx | output | IDX_W | Index of the last dirty-line failure |
| errTag | output | 1 | Last dirty-line failure involved the tag code |
| errData | output | 1 | Last dirty-line failure involved a word code |
| injEn | input | 1 | Test-only: apply injMask this cycle |
| injTag | input | 1 | Test-only: 1 targets {valid, tag}, 0 targets a data word |
| injIdx | input | IDX_W | Test-only: line index |
| injWord | input | OFF_W | Test-only: word within the line |
| injMask | input | 32 | Test-only: bits to flip (low TAG_W+1 bits for the tag field) |

## Verification
The bench injects an error into a word of a clean line other than the one it reads. A design that decoded only the requested word would return the data with no refill. It also flips one tag bit of a clean line, which still decodes to a match. A design that trusted the corrected tag would serve a hit where a refetch is required. On dirty lines it checks that no refill happens, because a refetch would silently discard the written value. It also checks that the single-bit error in the written word is corrected in the returned data, and that errTag and errData both read 1 once the tag and a word have both failed. Finally it checks that irq holds through idle cycles, and that a write miss allocates the line before it writes the word.

// File: rtl/eccc_pkg.sv
`timescale 1ns/1ps
package eccc_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_FILL = 2'd2
  } ctlState_e;

  typedef struct packed {
    logic accept;    // CPU request completes this cycle
    logic fillBeat;  // refill word arrives this cycle
    logic logErr;    // dirty-line check failure to record
  } ctlStrobe_t;

  // Number of Hamming check bits for k data bits (overall parity not included)
  function automatic int hamBits(input int k);
    int r;
    r = 1;
    for (int t = 0; t < 8; t++)
      if ((1 << r) < k + r + 1) r = r + 1;
    return r;
  endfunction

  // Check bits: [r-1:0] Hamming, [r] overall parity; data zero-extended to 32
  function automatic logic [7:0] secdedEnc(input logic [31:0] d, input int k);
    logic [7:0] c;
    int p;
    int r;
    c = '0;
    p = 2;
    r = hamBits(k);
    for (int i = 0; i < 32; i++) begin
      if (i < k) begin
        p = p + 1;
        if ((p & (p - 1)) == 0) p = p + 1;
        for (int j = 0; j < 7; j++)
          if (j < r && ((p >> j) & 1) == 1) c[j] = c[j] ^ d[i];
      end
    end
    c[r] = (^d) ^ (^c);
    return c;
  endfunction

  // Syndrome in [6:0], overall parity mismatch in [7]; zero means clean
  function automatic logic [7:0] secdedSyn(input logic [31:0] d, input logic [7:0] chk,
                                           input int k);
    logic [7:0] e;
    logic [7:0] s;
    int r;
    r = hamBits(k);
    e = secdedEnc(d, k);
    s = '0;
    for (int j = 0; j < 7; j++)
      if (j < r) s[j] = e[j] ^ chk[j];
    s[7] = (^d) ^ (^chk);
    return s;
  endfunction

  // Flip the data bit named by a single-error syndrome
  function automatic logic [31:0] secdedFix(input logic [31:0] d, input logic [7:0] s,
                                            input int k);
    logic [31:0] o;
    int p;
    o = d;
    p = 2;
    for (int i = 0; i < 32; i++) begin
      if (i < k) begin
        p = p + 1;
        if ((p & (p - 1)) == 0) p = p + 1;
        if (s[7] && int'(s[6:0]) == p) o[i] = ~d[i];
      end
    end
    return o;
  endfunction

  function automatic logic [1:0] vote3(input logic [1:0] a, input logic [1:0] b,
                                       input logic [1:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

endpackage

// File: rtl/eccc_datapath.sv
`timescale 1ns/1ps
module eccc_datapath
  import eccc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LINES  = 8,
  parameter int WORDS  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cpuWrite,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic [WORD_W-1:0]         cpuWdata,
  input  logic [WORD_W-1:0]         memRespData,
  input  ctlStrobe_t                strobe,
  input  logic                      injEn,
  input  logic                      injTag,
  input  logic [$clog2(LINES)-1:0]  injIdx,
  input  logic [$clog2(WORDS)-1:0]  injWord,
  input  logic [WORD_W-1:0]         injMask,
  output logic                      hit,
  output logic                      lineErr,
  output logic                      lineDirty,
  output logic                      fillLast,
  output logic [WORD_W-1:0]         respData,
  output logic [$clog2(LINES)-1:0]  errIdx,
  output logic                      errTag,
  output logic                      errData
);

  localparam int IDX_W  = $clog2(LINES);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int TAGV_W = TAG_W + 1;
  localparam int TCHK   = hamBits(TAGV_W) + 1;
  localparam int DCHK   = hamBits(WORD_W) + 1;

  logic [TAGV_W-1:0] tagQ     [LINES];
  logic [TCHK-1:0]   tagChkQ  [LINES];
  logic [WORD_W-1:0] dataQ    [LINES][WORDS];
  logic [DCHK-1:0]   dataChkQ [LINES][WORDS];
  logic [LINES-1:0]  dirtyQ;
  logic [OFF_W-1:0]  fillCnt;
  logic [WORD_W-1:0] respQ;
  logic [IDX_W-1:0]  errIdxQ;
  logic              errTagQ, errDataQ;

  logic [TAG_W-1:0]  reqTag;
  logic [IDX_W-1:0]  idx;
  logic [OFF_W-1:0]  off;

  assign reqTag = cpuAddr[ADDR_W-1 -: TAG_W];
  assign idx    = cpuAddr[OFF_W +: IDX_W];
  assign off    = cpuAddr[OFF_W-1:0];

  // Tag and valid check
  logic [7:0]        tagSyn;
  logic [TAGV_W-1:0] tagFix;
  logic              tagErr;

  assign tagSyn = secdedSyn(32'(tagQ[idx]), 8'(tagChkQ[idx]), TAGV_W);
  assign tagFix = TAGV_W'(secdedFix(32'(tagQ[idx]), tagSyn, TAGV_W));
  assign tagErr = |tagSyn;
  assign hit    = tagFix[TAG_W] && (tagFix[TAG_W-1:0] == reqTag);

  // Every word of the line is checked on each lookup
  logic [WORDS-1:0]  wordErr;
  logic [WORD_W-1:0] wordFix [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [7:0] syn;
    assign syn        = secdedSyn(dataQ[idx][w], 8'(dataChkQ[idx][w]), WORD_W);
    assign wordErr[w] = |syn;
    assign wordFix[w] = secdedFix(dataQ[idx][w], syn, WORD_W);
  end

  logic dataErr;
  assign dataErr   = |wordErr;
  assign lineErr   = tagErr || dataErr;
  assign lineDirty = dirtyQ[idx];
  assign fillLast  = (fillCnt == OFF_W'(WORDS - 1));

  // Encoders shared by all writers of the array
  logic [DCHK-1:0] wrChk, fillChk;
  logic [TCHK-1:0] newTagChk;

  assign wrChk     = DCHK'(secdedEnc(cpuWdata, WORD_W));
  assign fillChk   = DCHK'(secdedEnc(memRespData, WORD_W));
  assign newTagChk = TCHK'(secdedEnc(32'({1'b1, reqTag}), TAGV_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int l = 0; l < LINES; l++) begin
        tagQ[l]    <= '0;
        tagChkQ[l] <= '0;
        for (int w = 0; w < WORDS; w++) begin
          dataQ[l][w]    <= '0;
          dataChkQ[l][w] <= '0;
        end
      end
      dirtyQ   <= '0;
      fillCnt  <= '0;
      respQ    <= '0;
      errIdxQ  <= '0;
      errTagQ  <= 1'b0;
      errDataQ <= 1'b0;
    end else begin
      if (strobe.accept) begin
        respQ <= cpuWrite ? cpuWdata : wordFix[off];
        if (cpuWrite) begin
          dataQ[idx][off]    <= cpuWdata;
          dataChkQ[idx][off] <= wrChk;
          dirtyQ[idx]        <= 1'b1;
        end
      end
      if (strobe.fillBeat) begin
        dataQ[idx][fillCnt]    <= memRespData;
        dataChkQ[idx][fillCnt] <= fillChk;
        fillCnt                <= fillCnt + 1'b1;
        if (fillLast) begin
          tagQ[idx]    <= {1'b1, reqTag};
          tagChkQ[idx] <= newTagChk;
          dirtyQ[idx]  <= 1'b0;
        end
      end
      if (strobe.logErr) begin
        errIdxQ  <= idx;
        errTagQ  <= tagErr;
        errDataQ <= dataErr;
      end
      if (injEn) begin
        if (injTag) tagQ[injIdx] <= tagQ[injIdx] ^ injMask[TAGV_W-1:0];
        else        dataQ[injIdx][injWord] <= dataQ[injIdx][injWord] ^ injMask;
      end
    end
  end

  assign respData = respQ;
  assign errIdx   = errIdxQ;
  assign errTag   = errTagQ;
  assign errData  = errDataQ;

  // A completed refill leaves a clean line that the held request hits
  assert_refill_repairs_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillBeat && fillLast && !injEn) |=> (hit && !lineErr && !lineDirty));

endmodule

// File: rtl/eccc_control.sv
`timescale 1ns/1ps
module eccc_control
  import eccc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuValid,
  input  logic       memRespValid,
  input  logic       irqClear,
  input  logic       hit,
  input  logic       lineErr,
  input  logic       lineDirty,
  input  logic       fillLast,
  output logic       cpuReady,
  output logic       cpuRespValid,
  output logic       memReqValid,
  output logic       irq,
  output ctlStrobe_t strobe
);

  // Triplicated control flops, read through a majority vote
  logic [1:0] stCopy [3];
  logic [2:0] irqCopy, rspCopy;

  ctlState_e st, stNext;
  logic      lookupOk, irqNext;

  assign st           = ctlState_e'(vote3(stCopy[0], stCopy[1], stCopy[2]));
  assign irq          = maj3(irqCopy);
  assign cpuRespValid = maj3(rspCopy);

  // A hit is usable unless a clean line failed its check
  assign lookupOk = hit && !(lineErr && !lineDirty);

  always_comb begin
    stNext = st;
    case (st)
      ST_IDLE: if (cpuValid && !lookupOk) stNext = ST_REQ;
      ST_REQ:  stNext = ST_FILL;
      ST_FILL: if (memRespValid && fillLast) stNext = ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
  end

  assign cpuReady        = (st == ST_IDLE) && lookupOk;
  assign memReqValid     = (st == ST_REQ);
  assign strobe.accept   = cpuValid && cpuReady;
  assign strobe.fillBeat = (st == ST_FILL) && memRespValid;
  assign strobe.logErr   = (st == ST_IDLE) && cpuValid && lineErr && lineDirty;
  assign irqNext         = strobe.logErr || (irq && !irqClear);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) stCopy[i] <= ST_IDLE;
      irqCopy <= '0;
      rspCopy <= '0;
    end else begin
      for (int i = 0; i < 3; i++) stCopy[i] <= stNext;
      irqCopy <= {3{irqNext}};
      rspCopy <= {3{strobe.accept}};
    end
  end

  assert_stall_in_refill_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (st != ST_IDLE) |-> !cpuReady);

  assert_req_single_pulse_R3 : assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  assert_resp_after_accept_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuReady) |=> cpuRespValid);

  assert_dirty_fail_irq_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuReady && lineErr && lineDirty) |=> irq);

  assert_irq_holds_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClear) |=> irq);

endmodule

// File: rtl/ecc_refill_cache.sv
`timescale 1ns/1ps
module ecc_refill_cache
  import eccc_pkg::*;
#(
  parameter  int ADDR_W = 10,
  parameter  int LINES  = 8,
  parameter  int WORDS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(WORDS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cpuValid,
  output logic                  cpuReady,
  input  logic                  cpuWrite,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [31:0]           cpuWdata,
  output logic                  cpuRespValid,
  output logic [31:0]           cpuRdata,
  output logic                  memReqValid,
  output logic [ADDR_W-OFF_W-1:0] memReqAddr,
  input  logic                  memRespValid,
  input  logic [31:0]           memRespData,
  output logic                  irq,
  input  logic                  irqClear,
  output logic [IDX_W-1:0]      errIdx,
  output logic                  errTag,
  output logic                  errData,
  input  logic                  injEn,
  input  logic                  injTag,
  input  logic [IDX_W-1:0]      injIdx,
  input  logic [OFF_W-1:0]      injWord,
  input  logic [31:0]           injMask
);

  ctlStrobe_t strobe;
  logic       hit, lineErr, lineDirty, fillLast;

  assign memReqAddr = cpuAddr[ADDR_W-1:OFF_W];

  eccc_control u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .cpuValid     (cpuValid),
    .memRespValid (memRespValid),
    .irqClear     (irqClear),
    .hit          (hit),
    .lineErr      (lineErr),
    .lineDirty    (lineDirty),
    .fillLast     (fillLast),
    .cpuReady     (cpuReady),
    .cpuRespValid (cpuRespValid),
    .memReqValid  (memReqValid),
    .irq          (irq),
    .strobe       (strobe)
  );

  eccc_datapath #(
    .ADDR_W (ADDR_W),
    .LINES  (LINES),
    .WORDS  (WORDS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cpuWrite    (cpuWrite),
    .cpuAddr     (cpuAddr),
    .cpuWdata    (cpuWdata),
    .memRespData (memRespData),
    .strobe      (strobe),
    .injEn       (injEn),
    .injTag      (injTag),
    .injIdx      (injIdx),
    .injWord     (injWord),
    .injMask     (injMask),
    .hit         (hit),
    .lineErr     (lineErr),
    .lineDirty   (lineDirty),
    .fillLast    (fillLast),
    .respData    (cpuRdata),
    .errIdx      (errIdx),
    .errTag      (errTag),
    .errData     (errData)
  );

endmodule

// File: tb/ecc_refill_cache_tb.sv
`timescale 1ns/1ps
module ecc_refill_cache_tb;

  localparam int ADDR_W = 10;

  logic        clk, rstN;
  logic        cpuValid, cpuReady, cpuWrite;
  logic [9:0]  cpuAddr;
  logic [31:0] cpuWdata, cpuRdata;
  logic        cpuRespValid;
  logic        memReqValid;
  logic [7:0]  memReqAddr;
  logic        memRespValid;
  logic [31:0] memRespData;
  logic        irq, irqClear;
  logic [2:0]  errIdx;
  logic        errTag, errData;
  logic        injEn, injTag;
  logic [2:0]  injIdx;
  logic [1:0]  injWord;
  logic [31:0] injMask;

  int nChecks = 0;
  int nFail   = 0;
  int reqCnt  = 0;
  logic [7:0] lastReq;

  ecc_refill_cache #(.ADDR_W(ADDR_W), .LINES(8), .WORDS(4)) u_dut (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuReady(cpuReady), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRespValid(cpuRespValid), .cpuRdata(cpuRdata),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRespValid(memRespValid), .memRespData(memRespData),
    .irq(irq), .irqClear(irqClear),
    .errIdx(errIdx), .errTag(errTag), .errData(errData),
    .injEn(injEn), .injTag(injTag), .injIdx(injIdx), .injWord(injWord),
    .injMask(injMask)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] memWord(input logic [9:0] a);
    return {6'h2B, a, 6'h15, a};
  endfunction

  function automatic logic [9:0] mk(input int t, input int i, input int o);
    return {5'(t), 3'(i), 2'(o)};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Next-level memory model: 3 idle cycles, then four beats, word 0 first
  initial begin
    memRespValid = 1'b0;
    memRespData  = '0;
    forever begin
      @(negedge clk);
      if (memReqValid) begin
        reqCnt++;
        lastReq = memReqAddr;
        repeat (3) @(negedge clk);
        for (int b = 0; b < 4; b++) begin
          memRespValid = 1'b1;
          memRespData  = memWord({lastReq, 2'(b)});
          @(negedge clk);
        end
        memRespValid = 1'b0;
      end
    end
  end

  task automatic access(input logic wr, input logic [9:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic resp,
                        output int refills, output int stall);
    int r0;
    r0    = reqCnt;
    stall = 0;
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = d;
    #1;
    while (!cpuReady && stall < 200) begin
      @(negedge clk); #1;
      stall++;
    end
    @(negedge clk);
    cpuValid = 1'b0; cpuWrite = 1'b0;
    #1;
    rd      = cpuRdata;
    resp    = cpuRespValid;
    refills = reqCnt - r0;
  endtask

  task automatic inject(input logic isTag, input int i, input int w, input logic [31:0] m);
    @(negedge clk);
    injEn = 1'b1; injTag = isTag; injIdx = 3'(i); injWord = 2'(w); injMask = m;
    @(negedge clk);
    injEn = 1'b0;
  endtask

  task automatic clearIrq();
    @(negedge clk); irqClear = 1'b1;
    @(negedge clk); irqClear = 1'b0;
    #1;
  endtask

  logic [31:0] rd;
  logic        resp;
  int          nRef, stall;

  task automatic testReset();
    chk("R1", "cpuRespValid", 32'(cpuRespValid), 0);
    chk("R1", "irq", 32'(irq), 0);
    chk("R1", "memReqValid", 32'(memReqValid), 0);
    chk("R1", "cpuReady on invalid line", 32'(cpuReady), 0);
  endtask

  task automatic testColdMissAndHit();
    access(1'b0, mk(1, 2, 1), 0, rd, resp, nRef, stall);
    chk("R3", "cold miss refills", 32'(nRef), 1);
    chk("R3", "refill line address", 32'(lastReq), 32'(mk(1, 2, 1) >> 2));
    chk("R3", "stalled during refill", 32'(stall >= 4), 1);
    chk("R3", "replayed read data", rd, memWord(mk(1, 2, 1)));
    access(1'b0, mk(1, 2, 3), 0, rd, resp, nRef, stall);
    chk("R2", "hit no refill", 32'(nRef), 0);
    chk("R2", "hit response valid", 32'(resp), 1);
    chk("R2", "hit data", rd, memWord(mk(1, 2, 3)));
  endtask

  task automatic testWriteHit();
    access(1'b1, mk(1, 2, 1), 32'hDEADBEEF, rd, resp, nRef, stall);
    chk("R2", "write hit no refill", 32'(nRef), 0);
    access(1'b0, mk(1, 2, 1), 0, rd, resp, nRef, stall);
    chk("R2", "write readback", rd, 32'hDEADBEEF);
  endtask

  task automatic testCleanDataErr();
    access(1'b0, mk(3, 4, 0), 0, rd, resp, nRef, stall);
    inject(1'b0, 4, 2, 32'h0000_0020);
    access(1'b0, mk(3, 4, 0), 0, rd, resp, nRef, stall);
    chk("R4", "error in other word forces refill", 32'(nRef), 1);
    chk("R5", "clean data error read", rd, memWord(mk(3, 4, 0)));
    chk("R5", "no irq on clean line", 32'(irq), 0);
    access(1'b0, mk(3, 4, 2), 0, rd, resp, nRef, stall);
    chk("R5", "repaired line hits", 32'(nRef), 0);
    chk("R5", "repaired word data", rd, memWord(mk(3, 4, 2)));
  endtask

  task automatic testCleanTagErr();
    access(1'b0, mk(6, 5, 1), 0, rd, resp, nRef, stall);
    inject(1'b1, 5, 0, 32'h0000_0003);
    access(1'b0, mk(6, 5, 1), 0, rd, resp, nRef, stall);
    chk("R5", "double tag error refill", 32'(nRef), 1);
    chk("R5", "double tag error data", rd, memWord(mk(6, 5, 1)));
    inject(1'b1, 5, 0, 32'h0000_0004);
    access(1'b0, mk(6, 5, 3), 0, rd, resp, nRef, stall);
    chk("R5", "single tag error still refills", 32'(nRef), 1);
    chk("R5", "single tag error data", rd, memWord(mk(6, 5, 3)));
    chk("R5", "tag errors clean irq", 32'(irq), 0);
  endtask

  task automatic testDirtyDataErr();
    inject(1'b0, 2, 1, 32'h0002_0000);
    access(1'b0, mk(1, 2, 1), 0, rd, resp, nRef, stall);
    chk("R6", "dirty error no refill", 32'(nRef), 0);
    chk("R6", "dirty single error corrected", rd, 32'hDEADBEEF);
    chk("R6", "dirty error irq", 32'(irq), 1);
    chk("R7", "errIdx", 32'(errIdx), 2);
    chk("R7", "errData", 32'(errData), 1);
    chk("R7", "errTag", 32'(errTag), 0);
  endtask

  task automatic testIrqHoldClear();
    repeat (5) @(negedge clk);
    #1;
    chk("R8", "irq held while idle", 32'(irq), 1);
    clearIrq();
    chk("R8", "irq cleared", 32'(irq), 0);
  endtask

  task automatic testDirtyTagErr();
    inject(1'b1, 2, 0, 32'h0000_0001);
    access(1'b0, mk(1, 2, 3), 0, rd, resp, nRef, stall);
    chk("R6", "dirty tag error no refill", 32'(nRef), 0);
    chk("R6", "dirty tag error data", rd, memWord(mk(1, 2, 3)));
    chk("R6", "dirty tag error irq", 32'(irq), 1);
    chk("R7", "errTag after tag flip", 32'(errTag), 1);
    chk("R7", "errData still set", 32'(errData), 1);
    clearIrq();
  endtask

  task automatic testWriteMiss();
    access(1'b1, mk(9, 6, 2), 32'h1234_5678, rd, resp, nRef, stall);
    chk("R9", "write miss refills", 32'(nRef), 1);
    access(1'b0, mk(9, 6, 2), 0, rd, resp, nRef, stall);
    chk("R9", "write miss readback", rd, 32'h1234_5678);
    access(1'b0, mk(9, 6, 0), 0, rd, resp, nRef, stall);
    chk("R9", "other word from memory", rd, memWord(mk(9, 6, 0)));
    chk("R9", "no extra refill", 32'(nRef), 0);
  endtask

  task automatic testConflict();
    access(1'b0, mk(7, 4, 0), 0, rd, resp, nRef, stall);
    chk("R10", "conflict refills", 32'(nRef), 1);
    chk("R10", "conflict data", rd, memWord(mk(7, 4, 0)));
  endtask

  initial begin
    #(8 * 100000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; cpuValid = 1'b0; cpuWrite = 1'b0; cpuAddr = '0; cpuWdata = '0;
    irqClear = 1'b0; injEn = 1'b0; injTag = 1'b0; injIdx = '0; injWord = '0; injMask = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testColdMissAndHit();
    testWriteHit();
    testCleanDataErr();
    testCleanTagErr();
    testDirtyDataErr();
    testIrqHoldClear();
    testDirtyTagErr();
    testWriteMiss();
    testConflict();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule